// File: doc/BRIEF.md
# Bit-Field Extract Unit

This datapath unit pulls one contiguous run of bits out of a source word and returns it right-aligned. The caller supplies the source word, the index of the field's lowest bit and the field's length. A single mode bit chooses how the bits above the field are filled: with zeros, or with copies of the field's highest bit so that the field reads as a two's-complement number.

A request is presented by raising the input strobe for one cycle together with its operands. The result, an illegal-operand flag and an output strobe appear on the next clock edge. There is no back-pressure: the unit accepts a new request in every cycle, and the consumer must take each result in the cycle its strobe is high, because the result is not held for it. Between requests the result registers keep their last value. The unit generates no condition flags of any kind.

Top module: `bfx_unit`

## Requirements
- R1: A request is legal exactly when the length is at least 1 and the start index plus the length is at most 32; the start index is 5 bits (0 to 31) and the length is 6 bits (0 to 63).
- R2: For a legal request, result bits [len-1:0] equal source bits [pos+len-1:pos].
- R3: With the mode bit at 1 (signed) and a legal request, every result bit at index len or above equals source bit pos+len-1.
- R4: With the mode bit at 0 (unsigned) and a legal request, every result bit at index len or above is 0.
- R5: A length of 32 at start index 0 returns the source word unchanged in either mode.
- R6: An illegal request raises the illegal flag, drives the result to zero and still raises the output strobe; a legal request leaves the flag low.
- R7: The output strobe, result and flag reflect a request exactly one clock edge after it is presented, and back-to-back requests produce back-to-back results.
- R8: A synchronous active-high reset clears the output strobe, the result and the flag.
- R9: In a cycle with the input strobe low, the result and flag keep their previous values and the output strobe is low.
- R10: A 4-bit signed field at index 20 returns source bits 23..20 with bit 23 copied into bits 31..4; a 10-bit unsigned field at index 9 returns source bits 18..9 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_src | input | 32 | Source word |
| in_pos | input | 5 | Index of the field's lowest bit |
| in_len | input | 6 | Field length in bits |
| in_signed | input | 1 | 1: fill upper bits with field's top bit; 0: fill with zeros |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_data | output | 32 | Right-aligned, extended field |
| out_illegal | output | 1 | Start index and length were out of range |

## Verification
The hardest cases sit on the legality boundary, where start index plus length equals 32 exactly or exceeds it by one, and on lengths above 32 that only a 6-bit length port can carry; these are reached by sweeping every start index against lengths just below, at and above the limit. The sign fill only shows when the field's top bit is 1, so the sweep pairs each position and length with source words that set and clear that bit, including the all-ones, alternating and single-bit patterns. Back-to-back requests with alternating mode and legality check that no state leaks between consecutive results.

// File: rtl/bfx_pkg.sv
package bfx_pkg;
  typedef enum logic {
    EXT_ZERO = 1'b0,
    EXT_SIGN = 1'b1
  } ext_mode_e;
endpackage

// File: rtl/bfx_range_check.sv
module bfx_range_check #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic [POS_W-1:0] pos,
  input  logic [LEN_W-1:0] len,
  output logic             legal
);
  localparam int SUM_W = LEN_W + 1;

  logic [SUM_W-1:0] span_end;

  always_comb begin
    span_end = SUM_W'(pos) + SUM_W'(len);
    legal    = (len != '0) && (span_end <= SUM_W'(DATA_W));
  end
endmodule

// File: rtl/bfx_mask_gen.sv
module bfx_mask_gen #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = $clog2(DATA_W) + 1
) (
  input  logic [LEN_W-1:0]  len,
  output logic [DATA_W-1:0] keep
);
  always_comb begin
    if (len >= LEN_W'(DATA_W)) begin
      keep = '1;
    end else begin
      keep = (DATA_W'(1) << len) - DATA_W'(1);
    end
  end
endmodule

// File: rtl/bfx_extend.sv
module bfx_extend #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic [DATA_W-1:0] src,
  input  logic [POS_W-1:0]  pos,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] keep,
  input  bfx_pkg::ext_mode_e mode,
  output logic [DATA_W-1:0] field
);
  logic [DATA_W-1:0] aligned;
  logic [POS_W-1:0]  top_idx;
  logic              top_bit;
  logic              fill_bit;

  always_comb begin
    aligned  = src >> pos;
    top_idx  = (len == '0) ? '0 : POS_W'(len - LEN_W'(1));
    top_bit  = aligned[top_idx];
    fill_bit = (mode == bfx_pkg::EXT_SIGN) ? top_bit : 1'b0;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign field[i] = keep[i] ? aligned[i] : fill_bit;
  end
endmodule

// File: rtl/bfx_unit.sv
module bfx_unit #(
  parameter int DATA_W = 32,
  parameter int POS_W  = $clog2(DATA_W),
  parameter int LEN_W  = POS_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_src,
  input  logic [POS_W-1:0]  in_pos,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_signed,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  import bfx_pkg::*;

  logic              legal;
  logic [DATA_W-1:0] keep;
  logic [DATA_W-1:0] field;
  ext_mode_e         mode;

  assign mode = ext_mode_e'(in_signed);

  bfx_range_check #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_range (
    .pos  (in_pos),
    .len  (in_len),
    .legal(legal)
  );

  bfx_mask_gen #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_mask (
    .len (in_len),
    .keep(keep)
  );

  bfx_extend #(.DATA_W(DATA_W), .POS_W(POS_W), .LEN_W(LEN_W)) u_ext (
    .src  (in_src),
    .pos  (in_pos),
    .len  (in_len),
    .keep (keep),
    .mode (mode),
    .field(field)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= legal ? field : '0;
        out_illegal <= ~legal;
      end
    end
  end

  // R7: strobe follows request by one edge
  p_strobe_follows_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R9: no strobe without request, result held
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_illegal)));
  // R6: illegal result is zero
  p_illegal_zero_r6: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> (out_data == '0));
  // R1: zero length is always illegal
  p_zero_len_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_len == '0) |=> out_illegal);
  // R4: unsigned fill is zero above the field
  p_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && !in_signed) |=> ((out_data >> $past(in_len)) == '0));
  // R3: signed fill replicates the field's top bit
  p_sign_fill_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && legal && in_signed) |=>
      (((out_data >> ($past(in_len) - LEN_W'(1))) == '0) ||
       ((~out_data >> ($past(in_len) - LEN_W'(1))) == '0)));
endmodule

// File: tb/bfx_unit_tb.sv
`timescale 1ns/1ps
module bfx_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] in_src;
  logic [4:0]  in_pos;
  logic [5:0]  in_len;
  logic        in_signed;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_illegal;

  int n_checks = 0;
  int n_fails  = 0;

  always #2.5 clk = ~clk;

  bfx_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_src(in_src),
    .in_pos(in_pos), .in_len(in_len), .in_signed(in_signed),
    .out_valid(out_valid), .out_data(out_data), .out_illegal(out_illegal)
  );

  function automatic logic ref_legal(int pos, int len);
    return (len >= 1) && (pos + len <= 32);
  endfunction

  function automatic logic [31:0] ref_result(logic [31:0] src, int pos, int len, logic sgn);
    logic [31:0] r;
    r = '0;
    if (!ref_legal(pos, len)) return r;
    for (int i = 0; i < 32; i++) begin
      if (i < len) r[i] = src[pos + i];
      else         r[i] = sgn ? src[pos + len - 1] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [31:0] src, int pos, int len, logic sgn);
    in_valid  = v;
    in_src    = src;
    in_pos    = 5'(pos);
    in_len    = 6'(len);
    in_signed = sgn;
  endtask

  // one request, then check at the next falling edge
  task automatic one_shot(string req, logic [31:0] src, int pos, int len, logic sgn);
    @(negedge clk);
    drive(1'b1, src, pos, len, sgn);
    @(negedge clk);
    drive(1'b0, 32'h0, 0, 0, 1'b0);
    check({req, " valid"}, 32'(out_valid), 32'd1);
    check({req, " data"}, out_data, ref_result(src, pos, len, sgn));
    check({req, " illegal"}, 32'(out_illegal), 32'(!ref_legal(pos, len)));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    drive(1'b1, 32'hFFFF_FFFF, 0, 32, 1'b1);
    repeat (3) @(negedge clk);
    check("R8 valid", 32'(out_valid), 32'd0);
    check("R8 data", out_data, 32'd0);
    check("R8 illegal", 32'(out_illegal), 32'd0);
    drive(1'b0, 32'h0, 0, 0, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_examples;
    one_shot("R10 signed", 32'h0080_0000, 20, 4, 1'b1);
    check("R10 signed value", out_data, 32'hFFFF_FFF8);
    one_shot("R10 unsigned", 32'hFFFF_FFFF, 9, 10, 1'b0);
    check("R10 unsigned value", out_data, 32'h0000_03FF);
  endtask

  task automatic t_full_width;
    one_shot("R5 unsigned", 32'hDEAD_BEEF, 0, 32, 1'b0);
    check("R5 pass u", out_data, 32'hDEAD_BEEF);
    one_shot("R5 signed", 32'h8123_4567, 0, 32, 1'b1);
    check("R5 pass s", out_data, 32'h8123_4567);
  endtask

  task automatic t_illegal;
    one_shot("R6 zero len", 32'hFFFF_FFFF, 3, 0, 1'b1);
    one_shot("R1 over by one", 32'hFFFF_FFFF, 31, 2, 1'b1);
    one_shot("R1 exact edge", 32'h8000_0000, 31, 1, 1'b1);
    one_shot("R1 len 63", 32'hFFFF_FFFF, 0, 63, 1'b0);
    one_shot("R1 len 33", 32'h1234_5678, 0, 33, 1'b1);
  endtask

  task automatic t_hold;
    one_shot("R9 setup", 32'hF0F0_F0F0, 4, 8, 1'b1);
    @(negedge clk);
    drive(1'b0, 32'h0000_0000, 0, 0, 1'b0);
    @(negedge clk);
    check("R9 no strobe", 32'(out_valid), 32'd0);
    check("R9 data held", out_data, ref_result(32'hF0F0_F0F0, 4, 8, 1'b1));
    check("R9 flag held", 32'(out_illegal), 32'd0);
  endtask

  // back-to-back sweep: every position against lengths around the limit
  task automatic t_sweep;
    logic [31:0] pats [4];
    logic [31:0] p_src;
    int p_pos, p_len;
    logic p_sgn;
    logic pend;
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hAAAA_5555;
    pats[2] = 32'h8000_0001; pats[3] = 32'h0F1E_2D3C;
    pend = 1'b0;
    p_src = '0; p_pos = 0; p_len = 0; p_sgn = 1'b0;
    for (int pos = 0; pos < 32; pos++) begin
      for (int k = 0; k < 8; k++) begin
        int len;
        len = (k < 4) ? (32 - pos - 1 + k) : (k - 3);
        @(negedge clk);
        if (pend) begin
          check("R7 back-to-back valid", 32'(out_valid), 32'd1);
          check("R2 R3 R4 sweep data", out_data, ref_result(p_src, p_pos, p_len, p_sgn));
          check("R1 sweep flag", 32'(out_illegal), 32'(!ref_legal(p_pos, p_len)));
        end
        p_src = pats[(pos + k) % 4] ^ (32'h1 << ((pos + k) % 32));
        p_pos = pos; p_len = len; p_sgn = k[0];
        drive(1'b1, p_src, p_pos, p_len, p_sgn);
        pend = 1'b1;
      end
    end
    @(negedge clk);
    drive(1'b0, 32'h0, 0, 0, 1'b0);
    check("R2 sweep last", out_data, ref_result(p_src, p_pos, p_len, p_sgn));
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 32'h0, 0, 0, 1'b0);
    t_reset;
    t_examples;
    t_full_width;
    t_illegal;
    t_hold;
    t_sweep;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule